// File: doc/BRIEF.md
# Double-Buffered Parallel DAC Front End

This block is the digital side of an 8-bit voltage-output converter. A host drives an 8-bit data bus together with active-low select, write and load strobes, plus an active-low clear. A power-on strobe, low while the chip comes out of reset, also resets the block. Data written over the bus goes into an input latch. It is then copied into a second latch that holds the code the converter is showing. The code in that second latch is decoded into 30 segment-drive lines: each 4-bit half feeds its own 15-line thermometer decoder.

The load strobe decides when the second latch changes. The block samples the load strobe as a write closes. If it is low, the new code goes straight through as the write ends. If it is high, the code waits in the input latch until the load strobe falls. This lets several converters change their outputs together.

All strobes and data are resampled through two flops on a fast system clock before any edge is detected. A sticky flag reports a write that starts while the load strobe is still low after a deferred-mode write.

Top module: `dac_front`

## Requirements
- R1: A write happens while `cs_n` and `wr_n` are both low. The input latch follows `din` during the write and keeps the last value seen before the write closes.
- R2: If `ld_n` is low when a write closes, `code` takes the new value no later than three clock edges after the write strobe rises (immediate mode).
- R3: If `ld_n` is high when a write closes, `code` keeps its old value until `ld_n` falls. It takes the written value within three clock edges of that falling edge (deferred mode).
- R4: A falling edge on `ld_n` with no new write copies the unchanged input latch again, so `code` does not change.
- R5: Toggling `wr_n` while `cs_n` is high does not change the input latch.
- R6: While `clr_n` is low, the input latch, `code` and `seq_err` all go to zero, so all 30 segment lines are low.
- R7: While `por_n` is low, the block is reset the same way as in R6.
- R8: `seg_hi[i]` is 1 exactly when the upper nibble `code[7:4]` is greater than i. `seg_lo[i]` is 1 exactly when the lower nibble `code[3:0]` is greater than i, for i = 0..14.
- R9: `seq_err` goes high when a write starts while `ld_n` is low and the last completed write was in deferred mode. It stays high until a clear or a power-on reset. Writes in immediate mode only never set it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| por_n | input | 1 | Power-on strobe, active low, asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| ld_n | input | 1 | Load strobe, active low |
| clr_n | input | 1 | Clear, active low |
| din | input | 8 | Parallel data bus |
| code | output | 8 | Code held in the output latch |
| seg_hi | output | 15 | Thermometer lines for the upper nibble |
| seg_lo | output | 15 | Thermometer lines for the lower nibble |
| seq_err | output | 1 | Sticky protocol-violation flag |

## Verification
Every one of the 256 codes is written in immediate mode. This checks the data path and the thermometer weight of both nibbles at every value. A second sweep uses deferred mode on a stride of codes. It checks the held value between the write and the load pulse, which separates a latch that waits from one that updates early. Extra cases are a lone load pulse, a write with select high, a load strobe left low into the next write, and clear and power-on reset in mid-run. Each of these last cases is followed by a load pulse, so the input latch shows its contents at the outputs.

// File: rtl/dac_front.sv
module dac_front #(
  parameter int NIB = 4
) (
  input  logic                    clk,
  input  logic                    por_n,
  input  logic                    cs_n,
  input  logic                    wr_n,
  input  logic                    ld_n,
  input  logic                    clr_n,
  input  logic [2*NIB-1:0]        din,
  output logic [2*NIB-1:0]        code,
  output logic [(1<<NIB)-2:0]     seg_hi,
  output logic [(1<<NIB)-2:0]     seg_lo,
  output logic                    seq_err
);
  localparam int DW   = 2 * NIB;
  localparam int SEGS = (1 << NIB) - 1;

  logic [3:0]    st1, st2;
  logic [DW-1:0] d1, d2;
  logic [DW-1:0] in_lat, dac;
  logic          act_q, ld_q, mode_sync, err;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      st1 <= 4'hF;
      st2 <= 4'hF;
      d1  <= '0;
      d2  <= '0;
    end else begin
      st1 <= {clr_n, ld_n, wr_n, cs_n};
      st2 <= st1;
      d1  <= din;
      d2  <= d1;
    end

  wire cs_s  = st2[0];
  wire wr_s  = st2[1];
  wire ld_s  = st2[2];
  wire clr_s = st2[3];

  wire active   = !cs_s && !wr_s;
  wire wr_start = active && !act_q;
  wire wr_end   = act_q && !active;
  wire ld_fall  = ld_q && !ld_s;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      act_q     <= 1'b0;
      ld_q      <= 1'b1;
      in_lat    <= '0;
      dac       <= '0;
      mode_sync <= 1'b0;
      err       <= 1'b0;
    end else begin
      act_q <= active;
      ld_q  <= ld_s;
      if (!clr_s) begin
        in_lat    <= '0;
        dac       <= '0;
        mode_sync <= 1'b0;
        err       <= 1'b0;
      end else begin
        if (active) in_lat <= d2;
        if (wr_end) begin
          mode_sync <= ld_s;
          if (!ld_s) dac <= in_lat;
        end else if (ld_fall) begin
          dac <= in_lat;
        end
        if (wr_start && mode_sync && !ld_s) err <= 1'b1;
      end
    end

  for (genvar i = 0; i < SEGS; i++) begin : g_therm
    assign seg_hi[i] = dac[DW-1:NIB] > NIB'(i);
    assign seg_lo[i] = dac[NIB-1:0]  > NIB'(i);
  end

  assign code    = dac;
  assign seq_err = err;

  // R2
  auto_load_chk: assert property (@(posedge clk) disable iff (!por_n)
    (clr_s && wr_end && !ld_s) |=> (dac == $past(in_lat)));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (clr_s && !(wr_end && !ld_s) && !ld_fall) |=> $stable(dac));

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    !clr_s |=> (dac == '0 && in_lat == '0 && !err));

  // R8
  therm_chk: assert property (@(posedge clk) disable iff (!por_n)
    ($countones(seg_hi) == int'(dac[DW-1:NIB])) &&
    ($countones(seg_lo) == int'(dac[NIB-1:0])));

  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(err) |-> $past(wr_start && mode_sync && !ld_s));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    (err && clr_s) |=> err);
endmodule

// File: tb/sim_dac_front.sv
module sim_dac_front;
  localparam int CLK_P = 10;

  logic        clk = 0;
  logic        por_n = 0, cs_n = 1, wr_n = 1, ld_n = 1, clr_n = 1;
  logic [7:0]  din = '0;
  logic [7:0]  code;
  logic [14:0] seg_hi, seg_lo;
  logic        seq_err;
  int n_chk = 0, n_fail = 0;

  dac_front u0 (.clk, .por_n, .cs_n, .wr_n, .ld_n, .clr_n, .din,
                .code, .seg_hi, .seg_lo, .seq_err);

  always #(CLK_P/2) clk = ~clk;

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_code(string req, logic [7:0] e);
    logic [14:0] eh, el;
    eh = 15'((1 << e[7:4]) - 1);
    el = 15'((1 << e[3:0]) - 1);
    n_chk++;
    if (code !== e || seg_hi !== eh || seg_lo !== el) begin
      n_fail++;
      $display("FAIL %s: code=%h hi=%h lo=%h, expected code=%h hi=%h lo=%h",
               req, code, seg_hi, seg_lo, e, eh, el);
    end
  endtask

  task automatic chk_err(string req, logic e);
    n_chk++;
    if (seq_err !== e) begin
      n_fail++;
      $display("FAIL %s: seq_err=%b expected %b", req, seq_err, e);
    end
  endtask

  task automatic wr_cycle(logic [7:0] v, logic ld);
    @(negedge clk);
    ld_n = ld; din = v; cs_n = 0;
    wait_n(2); wr_n = 0;
    wait_n(4); wr_n = 1;
    wait_n(2); cs_n = 1;
    wait_n(5);
  endtask

  task automatic ld_pulse();
    @(negedge clk); ld_n = 0;
    wait_n(4); ld_n = 1;
    wait_n(5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait_n(3); por_n = 1; wait_n(3);
    chk_code("R7 reset", 8'h00);
    chk_err("R7 reset", 1'b0);

    // R1 R2 R8: every code in immediate mode
    for (int v = 0; v < 256; v++) begin
      wr_cycle(8'(v), 1'b0);
      chk_code("R2 immediate", 8'(v));
    end
    chk_err("R9 immediate only", 1'b0);

    // R4: lone load pulse
    ld_pulse();
    chk_code("R4 reload", 8'hFF);

    // R5: write with select high, then load pulse exposes input latch
    @(negedge clk); din = 8'h3C; wr_n = 0;
    wait_n(4); wr_n = 1; wait_n(4);
    ld_pulse();
    chk_code("R5 ignored", 8'hFF);

    // R3: deferred mode
    for (int v = 0; v < 256; v += 17) begin
      logic [7:0] prev;
      prev = code;
      wr_cycle(8'(v), 1'b1);
      chk_code("R3 hold", prev);
      ld_pulse();
      chk_code("R3 load", 8'(v));
    end
    chk_err("R9 clean deferred", 1'b0);

    // R9: load strobe left low into next write
    wr_cycle(8'h42, 1'b1);
    @(negedge clk); ld_n = 0; wait_n(5);
    chk_code("R3 load low", 8'h42);
    chk_err("R9 before", 1'b0);
    wr_cycle(8'h99, 1'b0);
    chk_err("R9 set", 1'b1);
    chk_code("R2 after violation", 8'h99);
    wr_cycle(8'h5A, 1'b0);
    chk_err("R9 sticky", 1'b1);

    // R6: clear
    @(negedge clk); ld_n = 1; clr_n = 0;
    wait_n(4); clr_n = 1; wait_n(5);
    chk_code("R6 clear", 8'h00);
    chk_err("R6 clear", 1'b0);
    ld_pulse();
    chk_code("R6 input latch", 8'h00);

    // R7: power-on strobe mid-run
    wr_cycle(8'hC3, 1'b0);
    chk_code("R2 before por", 8'hC3);
    @(negedge clk); por_n = 0;
    wait_n(2); por_n = 1; wait_n(4);
    chk_code("R7 por", 8'h00);
    ld_pulse();
    chk_code("R7 input latch", 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule